// File: doc/BRIEF.md
# Double-Data-Rate Burst SRAM Port Engine

This block is the synchronous front end of a double-data-rate burst memory with its storage array inside. Both halves of the external clock are modelled as one fast clock at twice the external rate. An internal phase bit, brought out as `kphase`, marks which half each fast cycle belongs to. A command is taken only in a `kphase=0` cycle. It is a write, a read or a no-operation, and it carries one address. Every write or read is a burst of two words. The first word goes to the loaded address. The second goes to that address with bit 0 inverted, so a burst never leaves its aligned pair.

Write data follows its command by one external cycle, one word per half. Read data appears two external cycles after the command, also one word per half, with `rvalid` and the output enable high only in those two fast cycles. A per-byte, active-low write select masks bytes of each write word. Writes wait in a one-burst pending register and reach the array only when the next write's data arrives. A read that hits the pending pair is served per byte from that register, so it always sees the latest earlier write.

The data path has a fixed latency and accepts a new command in every `kphase=0` cycle. There is therefore no ready signal and no back-pressure. The sender must present write data in the due cycles, and the receiver must take read data in the cycles `rvalid` is high.

Top module: `ddrb_port_engine`

## Requirements
- R1: In a `kphase=0` cycle c, `ld_n=0,rw=0` starts a write, `ld_n=0,rw=1` starts a read and `ld_n=1` is a no-operation. Command pins in `kphase=1` cycles have no effect.
- R2: For a write issued in cycle c, `wdata`/`bwe_n` in cycle c+2 are stored at address A and those in cycle c+3 at the second burst address.
- R3: For a read issued in cycle c, `rdata` carries the word at A in cycle c+4 and the word at the second burst address in cycle c+5.
- R4: The second burst address is A with bit 0 inverted. An odd A gives A then A-1.
- R5: `bwe_n[b]=1` in a write data cycle leaves byte b (bits 8b+7..8b) of that word unchanged, while `bwe_n[b]=0` writes it.
- R6: `rvalid` is high in exactly the read data cycles of R3. `rdata_oe` equals `rvalid`, and `rdata` is zero whenever `rdata_oe` is low.
- R7: `wdata` and `bwe_n` presented two and three cycles after a no-operation or a read change no stored word.
- R8: Commands may be issued in every `kphase=0` cycle, mixing reads and writes, with no stall cycle between them.
- R9: A read issued after a write returns that write's bytes even while the write is still pending, merged with older contents of any masked bytes.
- R10: A read issued before a write to the same pair returns the contents from before that write, even when its second word is fetched in the cycle the write's data arrives.
- R11: Reset clears `rvalid`, `rdata_oe` and `rdata`, cancels commands in flight, and makes the first cycle after release a `kphase=0` cycle, after which `kphase` alternates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, two cycles per external clock period |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_n | input | 1 | Active-low command strobe, taken in `kphase=0` cycles |
| rw | input | 1 | 1 selects read, 0 selects write |
| addr | input | AW | Word address of the burst |
| wdata | input | NB*BW | Write data word |
| bwe_n | input | NB | Active-low per-byte write select |
| kphase | output | 1 | 0 in the first half of the external clock, 1 in the second |
| rdata | output | NB*BW | Read data word |
| rdata_oe | output | 1 | Output enable for `rdata` |
| rvalid | output | 1 | High in cycles that carry read data |

## Verification
Counting a command's `kphase=0` cycle as c, write words are due in c+2 and c+3 and read words appear in c+4 and c+5. The bench walks its vector table one external cycle at a time. It drives the command of entry k together with the write data of entry k-1, and it checks the read words of entry k-2 in the same two fast cycles. Its reference memory applies each write only after the reads issued before it have taken their expected values, so command order sets the expected data without regard to when the array is actually written. Every fast cycle is sampled at the falling edge, and each check covers `rvalid`, `rdata_oe`, `rdata` and `kphase` at once.

// File: rtl/ddrb_pkg.sv
package ddrb_pkg;
  typedef enum logic [1:0] {
    CMD_NOP = 2'd0,
    CMD_WR  = 2'd1,
    CMD_RD  = 2'd2
  } cmd_e;
endpackage

// File: rtl/ddrb_cmd_pipe.sv
module ddrb_cmd_pipe
  import ddrb_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_n,
  input  logic          rw,
  input  logic [AW-1:0] addr,
  output logic          phase,
  output cmd_e          s1_kind,
  output logic [AW-1:0] s1_addr,
  output cmd_e          s2_kind,
  output logic [AW-1:0] s2_addr
);
  // two command stages, each advanced once per external cycle
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase   <= 1'b0;
      s1_kind <= CMD_NOP;
      s1_addr <= '0;
      s2_kind <= CMD_NOP;
      s2_addr <= '0;
    end else begin
      phase <= ~phase;
      if (!phase) begin
        s1_kind <= ld_n ? CMD_NOP : (rw ? CMD_RD : CMD_WR);
        s1_addr <= addr;
        s2_kind <= s1_kind;
        s2_addr <= s1_addr;
      end
    end
  end

  // R11
  phase_rise_chk: assert property (@(posedge clk) disable iff (!rst_n) !phase |=> phase);
  // R11
  phase_fall_chk: assert property (@(posedge clk) disable iff (!rst_n) phase |=> !phase);
  // R1
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phase |=> ($stable(s2_kind) && $stable(s2_addr)));
endmodule

// File: rtl/ddrb_wbuf.sv
module ddrb_wbuf
  import ddrb_pkg::*;
#(
  parameter int AW = 6,
  parameter int NB = 2,
  parameter int BW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             phase,
  input  cmd_e             s1_kind,
  input  logic [AW-1:0]    s1_addr,
  input  cmd_e             s2_kind,
  input  logic [AW-1:0]    s2_addr,
  input  logic [NB*BW-1:0] wdata,
  input  logic [NB-1:0]    bwe_n,
  input  logic [AW-1:0]    rd_addr,
  input  logic [NB*BW-1:0] mem_q,
  output logic [NB*BW-1:0] fwd_q,
  output logic             cm_en,
  output logic [AW-2:0]    cm_base,
  output logic [NB*BW-1:0] cm_data0,
  output logic [NB*BW-1:0] cm_data1,
  output logic [NB-1:0]    cm_be0,
  output logic [NB-1:0]    cm_be1
);
  localparam int DW = NB * BW;
  localparam int PW = AW - 1;

  logic          pv;
  logic [PW-1:0] pbase;
  logic [DW-1:0] pd  [2];
  logic [NB-1:0] pbe [2];
  logic          w0, w1, loc0, loc1, hit, ridx;

  assign w0   = !phase && (s1_kind == CMD_WR);
  assign w1   = phase && (s2_kind == CMD_WR);
  assign loc0 = s1_addr[0];
  assign loc1 = ~s2_addr[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pv    <= 1'b0;
      pbase <= '0;
      for (int i = 0; i < 2; i++) begin
        pd[i]  <= '0;
        pbe[i] <= '0;
      end
    end else begin
      if (w0) begin
        pv         <= 1'b1;
        pbase      <= s1_addr[AW-1:1];
        pd[loc0]   <= wdata;
        pbe[loc0]  <= ~bwe_n;
        pbe[~loc0] <= '0;
      end
      if (w1) begin
        pd[loc1]  <= wdata;
        pbe[loc1] <= ~bwe_n;
      end
    end
  end

  // the held burst moves to the array as the next write's first word lands
  assign cm_en    = w0 && pv;
  assign cm_base  = pbase;
  assign cm_data0 = pd[0];
  assign cm_data1 = pd[1];
  assign cm_be0   = pbe[0];
  assign cm_be1   = pbe[1];

  assign hit  = pv && (pbase == rd_addr[AW-1:1]);
  assign ridx = rd_addr[0];

  for (genvar b = 0; b < NB; b++) begin : g_fwd
    assign fwd_q[b*BW +: BW] = (hit && pbe[ridx][b]) ? pd[ridx][b*BW +: BW]
                                                      : mem_q[b*BW +: BW];
  end

  // R2
  word_order_chk: assert property (@(posedge clk) disable iff (!rst_n) w1 |-> pv);
  // R9
  pend_keep_chk: assert property (@(posedge clk) disable iff (!rst_n) pv |=> pv);
endmodule

// File: rtl/ddrb_array.sv
module ddrb_array #(
  parameter int AW = 6,
  parameter int NB = 2,
  parameter int BW = 8
) (
  input  logic             clk,
  input  logic             cm_en,
  input  logic [AW-2:0]    cm_base,
  input  logic [NB*BW-1:0] cm_data0,
  input  logic [NB*BW-1:0] cm_data1,
  input  logic [NB-1:0]    cm_be0,
  input  logic [NB-1:0]    cm_be1,
  input  logic [AW-1:0]    rd_addr,
  output logic [NB*BW-1:0] rd_q
);
  localparam int DW    = NB * BW;
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (cm_en) begin
      for (int b = 0; b < NB; b++) begin
        if (cm_be0[b]) mem[{cm_base, 1'b0}][b*BW +: BW] <= cm_data0[b*BW +: BW];
        if (cm_be1[b]) mem[{cm_base, 1'b1}][b*BW +: BW] <= cm_data1[b*BW +: BW];
      end
    end
  end

  assign rd_q = mem[rd_addr];
endmodule

// File: rtl/ddrb_port_engine.sv
module ddrb_port_engine
  import ddrb_pkg::*;
#(
  parameter int AW = 6,
  parameter int NB = 2,
  parameter int BW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_n,
  input  logic             rw,
  input  logic [AW-1:0]    addr,
  input  logic [NB*BW-1:0] wdata,
  input  logic [NB-1:0]    bwe_n,
  output logic             kphase,
  output logic [NB*BW-1:0] rdata,
  output logic             rdata_oe,
  output logic             rvalid
);
  localparam int DW = NB * BW;

  logic          phase;
  cmd_e          s1_kind, s2_kind;
  logic [AW-1:0] s1_addr, s2_addr, rd_addr;
  logic [DW-1:0] mem_q, fwd_q, cm_data0, cm_data1;
  logic [AW-2:0] cm_base;
  logic [NB-1:0] cm_be0, cm_be1;
  logic          cm_en, rd_go;

  ddrb_cmd_pipe #(.AW(AW)) u_cmd (
    .clk(clk), .rst_n(rst_n), .ld_n(ld_n), .rw(rw), .addr(addr),
    .phase(phase), .s1_kind(s1_kind), .s1_addr(s1_addr),
    .s2_kind(s2_kind), .s2_addr(s2_addr)
  );

  ddrb_wbuf #(.AW(AW), .NB(NB), .BW(BW)) u_wbuf (
    .clk(clk), .rst_n(rst_n), .phase(phase),
    .s1_kind(s1_kind), .s1_addr(s1_addr), .s2_kind(s2_kind), .s2_addr(s2_addr),
    .wdata(wdata), .bwe_n(bwe_n), .rd_addr(rd_addr), .mem_q(mem_q), .fwd_q(fwd_q),
    .cm_en(cm_en), .cm_base(cm_base), .cm_data0(cm_data0), .cm_data1(cm_data1),
    .cm_be0(cm_be0), .cm_be1(cm_be1)
  );

  ddrb_array #(.AW(AW), .NB(NB), .BW(BW)) u_arr (
    .clk(clk), .cm_en(cm_en), .cm_base(cm_base), .cm_data0(cm_data0),
    .cm_data1(cm_data1), .cm_be0(cm_be0), .cm_be1(cm_be1),
    .rd_addr(rd_addr), .rd_q(mem_q)
  );

  // first word is fetched at the end of a second-half cycle, the partner at the end of the next
  assign rd_go   = (s2_kind == CMD_RD);
  assign rd_addr = {s2_addr[AW-1:1], s2_addr[0] ^ ~phase};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rvalid <= 1'b0;
      rdata  <= '0;
    end else begin
      rvalid <= rd_go;
      rdata  <= rd_go ? fwd_q : '0;
    end
  end

  assign rdata_oe = rvalid;
  assign kphase   = phase;

  // R6
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rdata_oe |-> (rdata == '0));
  // R3
  burst_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rvalid && !phase) |=> rvalid);
  // R3
  burst_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rvalid && phase) |-> $past(rvalid));
endmodule

// File: tb/tb_ddrb_port_engine.sv
`timescale 1ns/1ps
module tb_ddrb_port_engine;
  localparam int N = 14;
  localparam logic [1:0] OP_N = 2'd0, OP_W = 2'd1, OP_R = 2'd2;

  // {tag[3:0], op[1:0], addr[5:0], d0[15:0], m0[1:0], d1[15:0], m1[1:0]}
  localparam logic [47:0] VEC [N] = '{
    {4'd2,  OP_W, 6'd4,  16'h1111, 2'b00, 16'h2222, 2'b00}, // R2 plain write
    {4'd4,  OP_W, 6'd7,  16'h3333, 2'b00, 16'h4444, 2'b00}, // R4 odd start wraps to 6
    {4'd3,  OP_R, 6'd4,  16'h0,    2'b00, 16'h0,    2'b00}, // R3 read timing
    {4'd4,  OP_R, 6'd7,  16'h0,    2'b00, 16'h0,    2'b00}, // R4 read order 7 then 6
    {4'd5,  OP_W, 6'd4,  16'hAAAA, 2'b10, 16'hBBBB, 2'b01}, // R5 byte masks
    {4'd9,  OP_R, 6'd4,  16'h0,    2'b00, 16'h0,    2'b00}, // R9 merged forward
    {4'd7,  OP_N, 6'd4,  16'h0,    2'b00, 16'h0,    2'b00}, // R7 nop, junk data follows
    {4'd7,  OP_R, 6'd4,  16'h0,    2'b00, 16'h0,    2'b00}, // R7 unchanged
    {4'd8,  OP_W, 6'd10, 16'h0101, 2'b00, 16'h0202, 2'b00}, // R8 back to back
    {4'd9,  OP_R, 6'd10, 16'h0,    2'b00, 16'h0,    2'b00}, // R9 read right after write
    {4'd8,  OP_W, 6'd11, 16'h7777, 2'b00, 16'h8888, 2'b00}, // R8
    {4'd10, OP_R, 6'd10, 16'h0,    2'b00, 16'h0,    2'b00}, // R10 read before write
    {4'd1,  OP_W, 6'd10, 16'h9999, 2'b00, 16'hCCCC, 2'b00}, // R1 write command
    {4'd8,  OP_R, 6'd11, 16'h0,    2'b00, 16'h0,    2'b00}  // R8
  };

  logic        clk = 1'b0, rst_n = 1'b0, ld_n = 1'b1, rw = 1'b0;
  logic [5:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [1:0]  bwe_n = 2'b11;
  logic        kphase, rdata_oe, rvalid;
  logic [15:0] rdata;
  logic [15:0] ref_mem [64];
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  ddrb_port_engine dut (
    .clk(clk), .rst_n(rst_n), .ld_n(ld_n), .rw(rw), .addr(addr),
    .wdata(wdata), .bwe_n(bwe_n), .kphase(kphase), .rdata(rdata),
    .rdata_oe(rdata_oe), .rvalid(rvalid)
  );

  always #2 clk = ~clk;

  function automatic logic [1:0]  f_op(input int k);  return VEC[k][43:42]; endfunction
  function automatic logic [5:0]  f_a(input int k);   return VEC[k][41:36]; endfunction
  function automatic logic [15:0] f_d0(input int k);  return VEC[k][35:20]; endfunction
  function automatic logic [1:0]  f_m0(input int k);  return VEC[k][19:18]; endfunction
  function automatic logic [15:0] f_d1(input int k);  return VEC[k][17:2];  endfunction
  function automatic logic [1:0]  f_m1(input int k);  return VEC[k][1:0];   endfunction
  function automatic int          f_tag(input int k); return int'(VEC[k][47:44]); endfunction

  task automatic ref_write(input logic [5:0] a, input logic [15:0] d, input logic [1:0] m);
    for (int b = 0; b < 2; b++)
      if (!m[b]) ref_mem[a][b*8 +: 8] = d[b*8 +: 8];
  endtask

  task automatic check(input bit ev, input logic [15:0] ed, input int tag, input bit eph);
    logic [15:0] exp_d;
    exp_d = ev ? ed : 16'h0;
    n_chk++;
    if (rvalid !== ev || rdata_oe !== ev || rdata !== exp_d || kphase !== eph) begin
      n_fail++;
      $display("FAIL R%0d: valid=%0b oe=%0b data=%h phase=%0b expected valid=%0b data=%h phase=%0b",
               tag, rvalid, rdata_oe, rdata, kphase, ev, exp_d, eph);
    end
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_fail++;
      $display("FAIL R11: watchdog expired actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    bit          ev;
    logic [15:0] e0, e1;
    int          tg;
    repeat (3) @(negedge clk);
    for (int k = 0; k < N + 2; k++) begin
      // first half of external cycle k
      @(negedge clk);
      ev = 1'b0; e0 = '0; e1 = '0; tg = 6; // R6 idle cycles
      if (k >= 2 && f_op(k-2) == OP_R) begin
        ev = 1'b1; tg = f_tag(k-2);
        e0 = ref_mem[f_a(k-2)];
        e1 = ref_mem[f_a(k-2) ^ 6'd1];
      end
      if (k >= 1 && f_op(k-1) == OP_W) begin
        ref_write(f_a(k-1), f_d0(k-1), f_m0(k-1));
        ref_write(f_a(k-1) ^ 6'd1, f_d1(k-1), f_m1(k-1));
      end
      check(ev, e0, (k == 0) ? 11 : tg, 1'b0); // R11 reset state at k=0
      if (k == 0) rst_n = 1'b1;
      if (k < N && f_op(k) != OP_N) begin
        ld_n = 1'b0; rw = (f_op(k) == OP_R); addr = f_a(k);
      end else begin
        ld_n = 1'b1; rw = 1'b0; addr = 6'd4;
      end
      if (k >= 1 && f_op(k-1) == OP_W) begin
        wdata = f_d0(k-1); bwe_n = f_m0(k-1);
      end else begin
        wdata = 16'hDEAD; bwe_n = 2'b00; // R7 junk data must be ignored
      end
      // second half of external cycle k
      @(negedge clk);
      check(ev, e1, tg, 1'b1);
      ld_n = 1'b0; rw = 1'b1; addr = 6'h3F; // R1 command pins ignored here
      if (k >= 1 && f_op(k-1) == OP_W) begin
        wdata = f_d1(k-1); bwe_n = f_m1(k-1);
      end else begin
        wdata = 16'hBEEF; bwe_n = 2'b00;
      end
    end

    // R11 reset while a read is in flight cancels it and realigns kphase
    @(negedge clk);
    ld_n = 1'b0; rw = 1'b1; addr = 6'd4;
    @(negedge clk);
    ld_n = 1'b1; rw = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) begin
      @(negedge clk);
      check(1'b0, 16'h0, 11, 1'b0);
    end
    @(negedge clk);
    check(1'b0, 16'h0, 11, 1'b0);
    rst_n = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check(1'b0, 16'h0, 11, (i % 2 == 0));
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule